// File: doc/BRIEF.md
# GPIO edge event channel unit

This block watches a bank of already-filtered, clock-synchronous GPIO inputs through eight independent event channels. Each channel is enabled on its own and has a pin selector. For the pin it selects, it produces single-cycle rise, fall and any-edge pulses. Any number of channels may watch the same pin, and each such channel reports on its own.

A small task side lets the events act in hardware with no processor in the loop. Each task channel names a source event channel, an event kind and a target output pin. The target pin inverts on the clock edge after a matching pulse. A rise-driven toggle fed by a square wave therefore produces a square wave at half the input frequency.

Channels are configured through a one-cycle write strobe with an address and a data word. Addresses 0 to 7 reach event channels 0 to 7. Addresses 8 to 15 reach task channels 0 to 7.

Top module: `gpio_evt_unit`

## Requirements
- R1: Eight event channels at addresses 0..7 take a write word with the selector in bits [4:0] and the enable in bit 5. A disabled channel drives 0 on all three of its event outputs.
- R2: An enabled channel with a valid selector raises its rise output for exactly one cycle when the selected pin is 1 at clock edge t and was 0 at edge t-1. The pulse is visible between edge t and edge t+1.
- R3: Under the same conditions and timing as R2, a 1-to-0 change of the selected pin raises the channel's fall output for one cycle.
- R4: The any-edge output pulses for one cycle on every level change of the selected pin, in the same cycle as the rise or fall pulse.
- R5: A selector value of 31 names no pin, and the channel produces no events while it holds that value.
- R6: Several channels that select the same pin each produce their events independently and identically.
- R7: A write to an event channel reloads its edge history from the newly selected pin, so no event is raised for the edge at which the write is taken, even if that pin changed there.
- R8: Task channels sit at addresses 8..15 and take a write word laid out as enable bit 0, source channel bits [3:1], kind bits [5:4] and target pin bits [10:6]. The kind codes are 0 for rise, 1 for fall and 2 for any-edge. An enabled task whose chosen event is pulsing inverts its target output on the next clock edge. With no enabled task, the outputs hold.
- R9: A rise-driven toggle task fed by a square wave on its source pin toggles its target once per input period, which is half the input frequency.
- R10: Toggles aimed at the same pin in the same cycle combine by exclusive-or, so two of them cancel. Kind code 3 never toggles, and a target value of 31 touches no output.
- R11: While reset is asserted and after its release, all event outputs and all output pins are 0, and every channel is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 31 | Filtered GPIO input levels |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Channel address (0..7 event, 8..15 task) |
| cfg_wdata | input | 11 | Configuration write word |
| evt_rise | output | 8 | Per-channel rise pulses |
| evt_fall | output | 8 | Per-channel fall pulses |
| evt_any | output | 8 | Per-channel any-edge pulses |
| pin_out | output | 31 | Task-driven output levels |

## Verification
The hardest case to reach from the ports is a configuration write that lands on the very edge where the newly selected pin changes level. The stimulus sets that pin and issues the write in the same cycle, then checks that no pulse appears and that the next real edge is still reported. A second hard case is two toggle tasks aimed at one pin in the same cycle. The stimulus creates it by routing two tasks from one event to the same target and checking that the output stays put. A long random phase then mixes pin noise with configuration writes, and every output is compared against the bench's behavioural model on every cycle.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;

  typedef enum logic [1:0] {
    KIND_RISE = 2'd0,
    KIND_FALL = 2'd1,
    KIND_ANY  = 2'd2,
    KIND_NONE = 2'd3
  } evt_kind_e;

  // returns {any, fall, rise} for a current and a previous sample
  function automatic logic [2:0] edge_flags(input logic cur, input logic prev);
    return {cur ^ prev, prev & ~cur, cur & ~prev};
  endfunction

  function automatic logic kind_hit(input evt_kind_e kind, input logic r,
                                    input logic f, input logic a);
    case (kind)
      KIND_RISE: return r;
      KIND_FALL: return f;
      KIND_ANY:  return a;
      default:   return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/gpio_evt_cfg.sv
module gpio_evt_cfg #(
  parameter int NUM_EVT  = 8,
  parameter int NUM_TASK = 8,
  parameter int SEL_W    = 5,
  parameter int SRC_W    = 3,
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 11
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cfg_we,
  input  logic [ADDR_W-1:0]               cfg_addr,
  input  logic [DATA_W-1:0]               cfg_wdata,
  output logic [NUM_EVT-1:0]              ch_en,
  output logic [NUM_EVT-1:0][SEL_W-1:0]   ch_sel,
  output logic [NUM_EVT-1:0]              ch_reload,
  output logic [SEL_W-1:0]                reload_sel,
  output logic [NUM_TASK-1:0]             task_en,
  output logic [NUM_TASK-1:0][SRC_W-1:0]  task_src,
  output logic [NUM_TASK-1:0][1:0]        task_kind,
  output logic [NUM_TASK-1:0][SEL_W-1:0]  task_tgt
);

  localparam int KIND_LSB = SRC_W + 1;
  localparam int TGT_LSB  = SRC_W + 3;

  assign reload_sel = cfg_wdata[SEL_W-1:0];

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
    assign ch_reload[i] = cfg_we && (cfg_addr == ADDR_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ch_en[i]  <= 1'b0;
        ch_sel[i] <= '0;
      end else if (ch_reload[i]) begin
        ch_en[i]  <= cfg_wdata[SEL_W];
        ch_sel[i] <= cfg_wdata[SEL_W-1:0];
      end
    end
  end

  for (genvar j = 0; j < NUM_TASK; j++) begin : g_task
    logic hit;
    assign hit = cfg_we && (cfg_addr == ADDR_W'(NUM_EVT + j));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        task_en[j]   <= 1'b0;
        task_src[j]  <= '0;
        task_kind[j] <= 2'd0;
        task_tgt[j]  <= '0;
      end else if (hit) begin
        task_en[j]   <= cfg_wdata[0];
        task_src[j]  <= cfg_wdata[SRC_W:1];
        task_kind[j] <= cfg_wdata[KIND_LSB+1:KIND_LSB];
        task_tgt[j]  <= cfg_wdata[TGT_LSB+SEL_W-1:TGT_LSB];
      end
    end
  end

endmodule

// File: rtl/gpio_evt_channel.sv
module gpio_evt_channel
  import gpio_evt_pkg::*;
#(
  parameter int NUM_PINS = 31,
  parameter int SEL_W    = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pins,
  input  logic                en,
  input  logic [SEL_W-1:0]    sel,
  input  logic                reload,
  input  logic [SEL_W-1:0]    reload_sel,
  output logic                rise,
  output logic                fall,
  output logic                any_edge
);

  localparam logic [SEL_W-1:0] PIN_LIMIT = SEL_W'(NUM_PINS);

  function automatic logic pick(input logic [NUM_PINS-1:0] v, input logic [SEL_W-1:0] s);
    logic r;
    r = 1'b0;
    for (int i = 0; i < NUM_PINS; i++) begin
      if (s == SEL_W'(i)) r = v[i];
    end
    return r;
  endfunction

  logic       samp_q, prev_q;
  logic       sel_valid;
  logic [2:0] flags;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q <= 1'b0;
      prev_q <= 1'b0;
    end else if (reload) begin
      samp_q <= pick(pins, reload_sel);
      prev_q <= pick(pins, reload_sel);
    end else begin
      samp_q <= pick(pins, sel);
      prev_q <= samp_q;
    end
  end

  assign sel_valid = en && (sel < PIN_LIMIT);
  assign flags     = edge_flags(samp_q, prev_q);
  assign rise      = sel_valid & flags[0];
  assign fall      = sel_valid & flags[1];
  assign any_edge  = sel_valid & flags[2];

  assert_disabled_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !(rise || fall || any_edge));
  assert_rise_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
  assert_fall_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);
  assert_any_covers_R4: assert property (@(posedge clk) disable iff (!rst_n)
    any_edge == (rise || fall));
  assert_bad_sel_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel >= PIN_LIMIT) |-> !any_edge);
  assert_reload_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> !any_edge);

endmodule

// File: rtl/gpio_evt_task.sv
module gpio_evt_task
  import gpio_evt_pkg::*;
#(
  parameter int NUM_PINS = 31,
  parameter int NUM_EVT  = 8,
  parameter int NUM_TASK = 8,
  parameter int SEL_W    = 5,
  parameter int SRC_W    = 3
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_EVT-1:0]              evt_rise,
  input  logic [NUM_EVT-1:0]              evt_fall,
  input  logic [NUM_EVT-1:0]              evt_any,
  input  logic [NUM_TASK-1:0]             task_en,
  input  logic [NUM_TASK-1:0][SRC_W-1:0]  task_src,
  input  logic [NUM_TASK-1:0][1:0]        task_kind,
  input  logic [NUM_TASK-1:0][SEL_W-1:0]  task_tgt,
  output logic [NUM_PINS-1:0]             pin_out
);

  logic [NUM_TASK-1:0] task_hit;
  logic [NUM_PINS-1:0] toggle_vec;

  always_comb begin
    for (int k = 0; k < NUM_TASK; k++) begin
      task_hit[k] = task_en[k] && kind_hit(evt_kind_e'(task_kind[k]),
                                           evt_rise[task_src[k]],
                                           evt_fall[task_src[k]],
                                           evt_any[task_src[k]]);
    end
  end

  // toggles aimed at the same pin cancel in pairs; out-of-range targets match nothing
  always_comb begin
    toggle_vec = '0;
    for (int k = 0; k < NUM_TASK; k++) begin
      for (int p = 0; p < NUM_PINS; p++) begin
        if (task_hit[k] && (task_tgt[k] == SEL_W'(p))) toggle_vec[p] = ~toggle_vec[p];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_out <= '0;
    else        pin_out <= pin_out ^ toggle_vec;
  end

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (task_en == '0) |=> $stable(pin_out));
  assert_hit_needs_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (task_hit != '0) |-> (evt_any != '0));

  for (genvar k = 0; k < NUM_TASK; k++) begin : g_chk
    assert_none_kind_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (task_kind[k] == 2'(KIND_NONE)) |-> !task_hit[k]);
  end

endmodule

// File: rtl/gpio_evt_unit.sv
module gpio_evt_unit #(
  parameter int NUM_PINS = 31,
  parameter int NUM_EVT  = 8,
  parameter int NUM_TASK = 8,
  localparam int SEL_W   = $clog2(NUM_PINS + 1),
  localparam int SRC_W   = $clog2(NUM_EVT),
  localparam int ADDR_W  = $clog2(NUM_EVT + NUM_TASK),
  localparam int DATA_W  = 1 + SRC_W + 2 + SEL_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic                cfg_we,
  input  logic [ADDR_W-1:0]   cfg_addr,
  input  logic [DATA_W-1:0]   cfg_wdata,
  output logic [NUM_EVT-1:0]  evt_rise,
  output logic [NUM_EVT-1:0]  evt_fall,
  output logic [NUM_EVT-1:0]  evt_any,
  output logic [NUM_PINS-1:0] pin_out
);

  logic [NUM_EVT-1:0]             ch_en, ch_reload;
  logic [NUM_EVT-1:0][SEL_W-1:0]  ch_sel;
  logic [SEL_W-1:0]               reload_sel;
  logic [NUM_TASK-1:0]            task_en;
  logic [NUM_TASK-1:0][SRC_W-1:0] task_src;
  logic [NUM_TASK-1:0][1:0]       task_kind;
  logic [NUM_TASK-1:0][SEL_W-1:0] task_tgt;

  gpio_evt_cfg #(
    .NUM_EVT(NUM_EVT), .NUM_TASK(NUM_TASK), .SEL_W(SEL_W),
    .SRC_W(SRC_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .ch_en(ch_en), .ch_sel(ch_sel),
    .ch_reload(ch_reload), .reload_sel(reload_sel), .task_en(task_en),
    .task_src(task_src), .task_kind(task_kind), .task_tgt(task_tgt)
  );

  for (genvar c = 0; c < NUM_EVT; c++) begin : g_ch
    gpio_evt_channel #(.NUM_PINS(NUM_PINS), .SEL_W(SEL_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .pins(pin_in), .en(ch_en[c]), .sel(ch_sel[c]),
      .reload(ch_reload[c]), .reload_sel(reload_sel),
      .rise(evt_rise[c]), .fall(evt_fall[c]), .any_edge(evt_any[c])
    );
  end

  gpio_evt_task #(
    .NUM_PINS(NUM_PINS), .NUM_EVT(NUM_EVT), .NUM_TASK(NUM_TASK),
    .SEL_W(SEL_W), .SRC_W(SRC_W)
  ) u_task (
    .clk(clk), .rst_n(rst_n), .evt_rise(evt_rise), .evt_fall(evt_fall),
    .evt_any(evt_any), .task_en(task_en), .task_src(task_src),
    .task_kind(task_kind), .task_tgt(task_tgt), .pin_out(pin_out)
  );

  // R6: two enabled channels watching one pin, neither just reloaded, agree
  for (genvar a = 1; a < NUM_EVT; a++) begin : g_pair
    assert_shared_pin_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(ch_en[0] && ch_en[a] && ch_sel[0] == ch_sel[a]
             && !ch_reload[0] && !ch_reload[a]) && $stable(ch_sel[0]) && $stable(ch_sel[a])
       && ch_en[0] && ch_en[a] && !$past(ch_reload[0]) && !$past(ch_reload[a]))
      |-> (evt_any[0] == evt_any[a]));
  end

endmodule

// File: tb/gpio_evt_unit_bench.sv
`timescale 1ns/1ps
module gpio_evt_unit_bench;
  localparam int NP = 31, NE = 8, NT = 8;

  logic        clk = 1'b0, rst_n = 1'b0, cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [10:0] cfg_wdata = '0;
  logic [30:0] pins = '0;
  logic [7:0]  evt_rise, evt_fall, evt_any;
  logic [30:0] pin_out;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  string phase = "R11";

  always #2 clk = ~clk;

  gpio_evt_unit u_gpio_evt_unit (
    .clk(clk), .rst_n(rst_n), .pin_in(pins), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .evt_rise(evt_rise), .evt_fall(evt_fall),
    .evt_any(evt_any), .pin_out(pin_out)
  );

  // behavioural reference
  bit          m_en[NE];
  int          m_sel[NE];
  bit          t_en[NT];
  int          t_src[NT], t_kind[NT], t_tgt[NT];
  logic [7:0]  er = '0, ef = '0, ea = '0;
  logic [30:0] eo = '0, lastp = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NE; i++) begin m_en[i] = 0; m_sel[i] = 0; end
      for (int i = 0; i < NT; i++) begin t_en[i] = 0; t_src[i] = 0; t_kind[i] = 0; t_tgt[i] = 0; end
      er = '0; ef = '0; ea = '0; eo = '0; lastp = '0;
    end else begin
      logic [30:0] tog;
      tog = '0;
      for (int k = 0; k < NT; k++) begin
        bit h;
        h = 0;
        if (t_kind[k] == 0) h = er[t_src[k]];
        else if (t_kind[k] == 1) h = ef[t_src[k]];
        else if (t_kind[k] == 2) h = ea[t_src[k]];
        if (t_en[k] && h && t_tgt[k] < NP) tog[t_tgt[k]] = ~tog[t_tgt[k]];
      end
      eo = eo ^ tog;
      for (int c = 0; c < NE; c++) begin
        bit live, now, was;
        live = m_en[c] && m_sel[c] < NP && !(cfg_we && cfg_addr == c);
        now  = live ? pins[m_sel[c]] : 1'b0;
        was  = live ? lastp[m_sel[c]] : 1'b0;
        er[c] = now && !was;
        ef[c] = !now && was;
        ea[c] = now != was;
      end
      if (cfg_we) begin
        if (cfg_addr < NE) begin
          m_en[cfg_addr]  = cfg_wdata[5];
          m_sel[cfg_addr] = int'(cfg_wdata[4:0]);
        end else begin
          t_en[cfg_addr-NE]   = cfg_wdata[0];
          t_src[cfg_addr-NE]  = int'(cfg_wdata[3:1]);
          t_kind[cfg_addr-NE] = int'(cfg_wdata[5:4]);
          t_tgt[cfg_addr-NE]  = int'(cfg_wdata[10:6]);
        end
      end
      lastp = pins;
    end
  end

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", phase, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("evt_rise vs model", 32'(evt_rise), 32'(er));
      chk("evt_fall vs model", 32'(evt_fall), 32'(ef));
      chk("evt_any vs model",  32'(evt_any),  32'(ea));
      chk("pin_out vs model",  32'(pin_out),  32'(eo));
    end
  end

  function automatic logic [10:0] ev(bit en, int sel);
    return {5'd0, en, 5'(sel)};
  endfunction
  function automatic logic [10:0] tk(bit en, int src, int kind, int tgt);
    return {5'(tgt), 2'(kind), 3'(src), en};
  endfunction

  task automatic wr(int addr, logic [10:0] data);
    cfg_we = 1'b1; cfg_addr = 4'(addr); cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #600000;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int flips;
    logic last10;
    repeat (3) @(negedge clk);
    phase = "R11";
    chk("R11 rise at reset", 32'(evt_rise), 0);
    chk("R11 any at reset",  32'(evt_any),  0);
    chk("R11 pin_out at reset", 32'(pin_out), 0);
    rst_n = 1'b1;
    pins = 31'h7fff_ffff;
    repeat (2) @(negedge clk);
    chk("R11 channels disabled after release", 32'(evt_any), 0);
    pins = '0;
    @(negedge clk);

    phase = "R1";
    wr(0, ev(1, 3)); wr(1, ev(1, 3)); wr(2, ev(1, 31)); wr(3, ev(0, 3));
    @(negedge clk);
    phase = "R6";
    pins[3] = 1'b1;
    @(negedge clk);
    chk("R2 ch0 rise", 32'(evt_rise[0]), 1);
    chk("R6 ch1 rise with ch0", 32'(evt_rise[1]), 1);
    chk("R5 ch2 sel31 quiet", 32'(evt_any[2]), 0);
    chk("R1 ch3 disabled quiet", 32'(evt_any[3]), 0);
    @(negedge clk);
    chk("R2 rise lasts one cycle", 32'(evt_rise[0]), 0);
    pins[3] = 1'b0;
    @(negedge clk);
    chk("R3 ch0 fall", 32'(evt_fall[0]), 1);
    chk("R4 ch0 any with fall", 32'(evt_any[0]), 1);
    chk("R3 no rise on fall", 32'(evt_rise[0]), 0);

    phase = "R7";
    pins[5] = 1'b1;
    wr(4, ev(1, 5));
    chk("R7 no event at write edge", 32'(evt_any[4]), 0);
    pins[5] = 1'b0;
    @(negedge clk);
    chk("R7 later fall reported", 32'(evt_fall[4]), 1);

    phase = "R8";
    wr(8, tk(1, 0, 0, 10));
    @(negedge clk);
    pins[3] = 1'b1;
    @(negedge clk);
    chk("R8 target unchanged during pulse", 32'(pin_out[10]), 0);
    @(negedge clk);
    chk("R8 target toggled edge after pulse", 32'(pin_out[10]), 1);
    pins[3] = 1'b0;
    repeat (3) @(negedge clk);

    phase = "R9";
    flips = 0;
    last10 = pin_out[10];
    for (int n = 0; n < 32; n++) begin
      pins[3] = (n % 4) < 2;
      @(negedge clk);
      if (pin_out[10] !== last10) flips++;
      last10 = pin_out[10];
    end
    repeat (3) @(negedge clk);
    if (pin_out[10] !== last10) flips++;
    chk("R9 one output toggle per input period", 32'(flips), 8);

    phase = "R10";
    wr(9, tk(1, 0, 0, 10));
    wr(10, tk(1, 1, 3, 14));
    wr(11, tk(1, 1, 2, 31));
    last10 = pin_out[10];
    pins[3] = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 paired toggles cancel", 32'(pin_out[10]), 32'(last10));
    chk("R10 kind 3 never toggles", 32'(pin_out[14]), 0);
    chk("R10 target 31 touches nothing", 32'(pin_out & ~(31'h1 << 10)), 0);
    pins[3] = 1'b0;
    @(negedge clk);

    phase = "R2 R3 R4 R6 R8 random";
    for (int n = 0; n < 4000; n++) begin
      pins = 31'($urandom);
      if (($urandom % 6) == 0) begin
        cfg_we = 1'b1; cfg_addr = 4'($urandom); cfg_wdata = 11'($urandom);
      end else begin
        cfg_we = 1'b0;
      end
      @(negedge clk);
    end
    cfg_we = 1'b0;
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule